// File: doc/BRIEF.md
# Sound Unit Status and Channel Enable Register

This block holds the single status/enable location of a five-voice sound unit sitting on an 8-bit processor bus. A bus write loads the five per-voice enable outputs (two square voices, the triangle voice, the noise voice and the sample-playback voice) and drops any pending sample-playback interrupt. A bus read returns a summary byte. The summary shows which voices are still sounding, whether sample playback still has bytes left to fetch, and which interrupt sources are pending. The read also clears the frame-sequencer interrupt once the byte has been captured.

The voices, their length counters, the frame sequencer and the sample fetch engine all live outside this block. They report through level flags (length counter nonzero, bytes remaining nonzero) and through single-cycle set pulses for the two interrupt sources. The block merges both pending interrupts onto one interrupt line. A peek input lets a debugger read the same byte with no side effects.

Top module: `snd_status_reg`

## Requirements
- R1: While rst_ni is low, chan_en_o is 0, both interrupt flags are clear and irq_o is 0.
- R2: When sel_i and rd_i are high in a cycle, rdata_o[3:0] in that cycle equals len_active_i, with bit 0 for square voice 1, bit 1 for square voice 2, bit 2 for the triangle voice and bit 3 for the noise voice.
- R3: During a read, rdata_o[4] equals dmc_busy_i and rdata_o[5] is always 0.
- R4: A frame_irq_set_i pulse makes the frame flag pending from the next cycle, shown at rdata_o[6]. A dmc_irq_set_i pulse makes the sample interrupt flag pending from the next cycle, shown at rdata_o[7].
- R5: A read (sel_i and rd_i high) returns the current frame flag and clears it from the next cycle on.
- R6: If frame_irq_set_i is high in the same cycle as a clearing read, the frame flag stays pending.
- R7: A write (sel_i and wr_i high) loads chan_en_o from wdata_i[4:0] in the next cycle, with bit 0 for square 1, then square 2, triangle, noise, and bit 4 for sample playback. wdata_i[7:5] have no effect.
- R8: Any write clears the sample interrupt flag from the next cycle, unless dmc_irq_set_i is high in that same cycle. A write leaves the frame flag unchanged.
- R9: irq_o is high exactly when the frame flag or the sample interrupt flag is pending.
- R10: When peek_i is high, rdata_o shows the same status byte as a read, and no flag is cleared.
- R11: rdata_o is 0 when neither a selected read nor a peek is active. rd_i or wr_i without sel_i changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select |
| rd_i | input | 1 | Read strobe, single cycle |
| wr_i | input | 1 | Write strobe, single cycle |
| peek_i | input | 1 | Side-effect-free debug read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the strobe cycle |
| len_active_i | input | 4 | Length counter nonzero flags, one per voice |
| dmc_busy_i | input | 1 | Sample playback has bytes remaining |
| frame_irq_set_i | input | 1 | Frame interrupt set pulse |
| dmc_irq_set_i | input | 1 | Sample interrupt set pulse |
| chan_en_o | output | 5 | Per-voice enables |
| irq_o | output | 1 | Merged interrupt request |

## Verification
The bound checker watches on every cycle that enables change only on a selected write, that read data mirrors the live activity inputs, that bit 5 stays zero, and that idle cycles drive zero data. It also checks that set pulses always win against a clearing access in the same cycle, and that the interrupt line matches the two flag bits whenever they are visible. Only the bench scenarios show complete sequences: a read that clears one flag but leaves the other, a write that drops the sample interrupt while the frame interrupt stays, strobes without select that have no effect, and a peek that repeats the same byte cycle after cycle.

// File: rtl/snd_status_pkg.sv
package snd_status_pkg;
  localparam int DATA_W   = 8;
  localparam int LEN_CH   = 4;
  localparam int EN_W     = 5;
  // status byte positions decoded by software
  localparam int BIT_BUSY  = 4;
  localparam int BIT_FRAME = 6;
  localparam int BIT_DIRQ  = 7;

  typedef struct packed {
    logic frame;
    logic dmc;
  } irq_flags_t;
endpackage

// File: rtl/snd_irq_flag.sv
module snd_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set beats clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/snd_enable_reg.sv
module snd_enable_reg #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/snd_status_mux.sv
module snd_status_mux
  import snd_status_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int LC = LEN_CH
) (
  input  logic          show_i,
  input  logic [LC-1:0] len_active_i,
  input  logic          dmc_busy_i,
  input  irq_flags_t    flags_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] status;

  always_comb begin
    status              = '0;
    status[LC-1:0]      = len_active_i;
    status[BIT_BUSY]    = dmc_busy_i;
    status[BIT_FRAME]   = flags_i.frame;
    status[BIT_DIRQ]    = flags_i.dmc;
  end

  assign rdata_o = show_i ? status : '0;
endmodule

// File: rtl/snd_status_reg.sv
module snd_status_reg
  import snd_status_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int LC = LEN_CH,
  parameter int EW = EN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          peek_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [LC-1:0] len_active_i,
  input  logic          dmc_busy_i,
  input  logic          frame_irq_set_i,
  input  logic          dmc_irq_set_i,
  output logic [EW-1:0] chan_en_o,
  output logic          irq_o
);
  logic       rd_hit, wr_hit;
  irq_flags_t flags;

  assign rd_hit = sel_i & rd_i;
  assign wr_hit = sel_i & wr_i;

  snd_irq_flag u_frame_flag (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (frame_irq_set_i), .clr_i (rd_hit),
    .flag_o(flags.frame)
  );

  snd_irq_flag u_dmc_flag (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (dmc_irq_set_i), .clr_i (wr_hit),
    .flag_o(flags.dmc)
  );

  snd_enable_reg #(.W(EW)) u_enable (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .load_i(wr_hit), .d_i (wdata_i[EW-1:0]),
    .q_o   (chan_en_o)
  );

  snd_status_mux #(.DW(DW), .LC(LC)) u_mux (
    .show_i      (rd_hit | peek_i),
    .len_active_i(len_active_i),
    .dmc_busy_i  (dmc_busy_i),
    .flags_i     (flags),
    .rdata_o     (rdata_o)
  );

  assign irq_o = flags.frame | flags.dmc;
endmodule

// File: rtl/snd_status_chk.sv
module snd_status_chk #(
  parameter int DW = 8,
  parameter int LC = 4,
  parameter int EW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sel_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic          peek_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [LC-1:0] len_active_i,
  input logic          dmc_busy_i,
  input logic          frame_irq_set_i,
  input logic          dmc_irq_set_i,
  input logic [EW-1:0] chan_en_o,
  input logic          irq_o
);
  p_bits_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rd_i) |-> rdata_o[LC-1:0] == len_active_i);
  p_busy_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rd_i) |-> (rdata_o[4] == dmc_busy_i && !rdata_o[5]));
  p_frame_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_irq_set_i |=> irq_o);
  p_read_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rd_i && !frame_irq_set_i && !dmc_irq_set_i && !rdata_o[7]
     && !(sel_i && wr_i && 1'b0)) |=> !irq_o);
  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rd_i && frame_irq_set_i) |=> irq_o);
  p_en_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i) |=> chan_en_o == $past(wdata_i[EW-1:0]));
  p_en_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_i) |=> $stable(chan_en_o));
  p_dmc_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && dmc_irq_set_i) |=> irq_o);
  p_irq_or_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sel_i && rd_i) || peek_i) |-> irq_o == (rdata_o[6] || rdata_o[7]));
  p_peek_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peek_i && !(sel_i && rd_i) && rdata_o[6]) |=> irq_o);
  p_idle_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(sel_i && rd_i) && !peek_i) |-> rdata_o == '0);
endmodule

bind snd_status_reg snd_status_chk #(.DW(DW), .LC(LC), .EW(EW)) u_chk (.*);

// File: tb/tb_snd_status_reg.sv
module tb_snd_status_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 0, rd_i = 0, wr_i = 0, peek_i = 0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [3:0] len_active_i = '0;
  logic       dmc_busy_i = 0, frame_irq_set_i = 0, dmc_irq_set_i = 0;
  logic [4:0] chan_en_o;
  logic       irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    string      req;
    logic [7:0] rd;
    logic [4:0] en;
    logic       irq;
  } item_t;
  item_t q[$];

  // reference state derived from the requirements
  bit       m_frame = 0, m_dmc = 0;
  bit [4:0] m_en = '0;

  always #10 clk_i = ~clk_i;

  snd_status_reg dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit s, bit r, bit w, bit p, logic [7:0] wd,
                      logic [3:0] len, bit busy, bit fset, bit dset);
    item_t it;
    @(negedge clk_i);
    sel_i = s; rd_i = r; wr_i = w; peek_i = p; wdata_i = wd;
    len_active_i = len; dmc_busy_i = busy;
    frame_irq_set_i = fset; dmc_irq_set_i = dset;
    it.req = req;
    it.rd  = ((s && r) || p) ? {m_dmc, m_frame, 1'b0, busy, len} : 8'h00;
    it.en  = m_en;
    it.irq = m_frame | m_dmc;
    q.push_back(it);
    if (fset) m_frame = 1; else if (s && r) m_frame = 0;
    if (dset) m_dmc = 1;   else if (s && w) m_dmc = 0;
    if (s && w) m_en = wd[4:0];
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk_i);
      #8;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(it.req, rdata_o, it.rd, "rdata");
        chk(it.req, chan_en_o, it.en, "chan_en");
        chk(it.req, irq_o, it.irq, "irq");
      end
    end
  end

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    #15;
    chk("R1", chan_en_o, 5'h00, "chan_en in reset");
    chk("R1", irq_o, 1'b0, "irq in reset");
    @(negedge clk_i); rst_ni = 1'b1;

    step("R11", 0,0,0,0, 8'h00, 4'h0, 0, 0, 0);
    step("R2",  1,1,0,0, 8'h00, 4'b1010, 1, 0, 0);   // expect 8'h1A
    step("R3",  1,1,0,0, 8'h00, 4'b0000, 1, 0, 0);   // expect 8'h10
    step("R10", 0,0,0,1, 8'h00, 4'b0101, 0, 0, 0);
    step("R4",  0,0,0,0, 8'h00, 4'h0, 0, 1, 0);      // frame set
    step("R4",  0,0,0,1, 8'h00, 4'h0, 0, 0, 0);      // peek 8'h40
    step("R10", 0,0,0,1, 8'h00, 4'h0, 0, 0, 0);      // still 8'h40
    step("R5",  1,1,0,0, 8'h00, 4'h0, 0, 0, 0);      // read returns flag
    step("R5",  0,0,0,1, 8'h00, 4'h0, 0, 0, 0);      // now clear
    step("R6",  0,0,0,0, 8'h00, 4'h0, 0, 1, 0);
    step("R6",  1,1,0,0, 8'h00, 4'h0, 0, 1, 0);      // set beats clear
    step("R6",  0,0,0,1, 8'h00, 4'h0, 0, 0, 0);
    step("R11", 0,1,0,0, 8'h00, 4'h0, 0, 0, 0);      // rd without sel
    step("R11", 0,0,0,1, 8'h00, 4'h0, 0, 0, 0);
    step("R5",  1,1,0,0, 8'h00, 4'h0, 0, 0, 0);
    step("R4",  0,0,0,0, 8'h00, 4'h0, 0, 0, 1);      // dmc set
    step("R9",  0,0,0,1, 8'h00, 4'h0, 0, 0, 0);      // peek 8'h80
    step("R7",  1,0,1,0, 8'hFF, 4'h0, 0, 0, 0);      // write all ones
    step("R8",  0,0,0,1, 8'h00, 4'h0, 0, 0, 0);      // dmc cleared, en 1F
    step("R8",  1,0,1,0, 8'hEA, 4'h0, 0, 0, 1);      // set beats write-clear
    step("R7",  0,0,0,1, 8'h00, 4'h0, 0, 0, 0);      // en 0A, dmc pending
    step("R11", 0,0,1,0, 8'h15, 4'h0, 0, 0, 0);      // wr without sel
    step("R11", 0,0,0,1, 8'h00, 4'h0, 0, 0, 0);
    step("R9",  0,0,0,0, 8'h00, 4'h0, 0, 1, 0);      // both pending
    step("R9",  0,0,0,1, 8'h00, 4'hF, 1, 0, 0);      // 8'hDF
    step("R8",  1,0,1,0, 8'h00, 4'h0, 0, 0, 0);      // write keeps frame
    step("R8",  0,0,0,1, 8'h00, 4'h0, 0, 0, 0);      // 8'h40
    step("R5",  1,1,1,0, 8'h13, 4'h0, 0, 0, 0);
    step("R9",  0,0,0,1, 8'h00, 4'h0, 0, 0, 0);      // all clear, en 13
    step("R11", 0,0,0,0, 8'h00, 4'h0, 0, 0, 0);

    @(negedge clk_i); @(negedge clk_i);
    #9;
    chk("R7", chan_en_o, 5'h13, "final chan_en");
    chk("R9", irq_o, 1'b0, "final irq");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule